// File: doc/BRIEF.md
# Background Calibration Correlator Engine

This block works in the background on the output codes of a replica converter path whose analog input is held at midscale. It produces a four-level calibration stimulus from two independent pseudo-random bit streams. Each stream holds its value for 64 accepted samples. The block also correlates every replica sample against three sign sequences taken from those streams, so the coefficient logic further down the chip can estimate distortion terms from the results.

The same sample windows also feed a centre-frequency servo. The servo sums the replica output over a window, scales the sum by a power-of-two gain and subtracts the scaled value from an 8-bit bias code. This negative feedback drives the mean of the replica output towards zero, and with a matched gain the loop settles in one update. The bias code drives the replica's bias DAC and is also routed to the main signal paths.

Samples arrive on a valid/ready stream. The block never applies back-pressure: `s_ready` rises one cycle after reset is released and then stays high. A sample is taken on every rising edge where both `s_valid` and `s_ready` are high. Cycles where `s_valid` is low change nothing.

Top module: `cal_corr_engine`

## Requirements
- R1: After reset, `s_ready` is high. A sample is consumed only on an edge where `s_valid` and `s_ready` are both high. Edges without a consumed sample leave every output unchanged and raise no `done`.
- R2: `stim_code[1]` is bit 6 of LFSR A and `stim_code[0]` is bit 6 of LFSR B. Each LFSR is 7 bits wide and steps as s <= {s[5:0], s[6]^s[5]}. The reset seeds are 7'h01 for A and 7'h5A for B.
- R3: Both LFSRs step together on the edge that consumes the 64th, 128th, ... sample after reset. Any other edge leaves them unchanged.
- R4: Each consumed sample d is added to three correlators as +d when the chosen sign bit is 1 and as -d when it is 0. The sign bits are: `corr_a` uses stream A, `corr_b` uses stream B, `corr_ab` uses NOT(A XOR B). The bits used are the stim values in force before that edge.
- R5: A window holds `cfg_len` consumed samples, and a value of 0 counts as 1. The edge that consumes the last sample of a window loads the results, including that sample, and clears the accumulators.
- R6: Every accumulator (the three correlators and the frequency sum) saturates at -2^(ACC_W-1) and 2^(ACC_W-1)-1 (ACC_W = 20). No accumulator wraps.
- R7: At each window end, `fc_code` becomes fc - floor(S / 2^GAIN_SHIFT), where S is the saturated window sum and GAIN_SHIFT = 4.
- R8: `fc_code` is clamped to the range 0 to 255 and resets to 128.
- R9: `done` is high for exactly the cycle after each window-ending edge. Between updates, the correlation results and `fc_code` hold their values.
- R10: In reset, the correlation results are 0, `fc_code` is 128, `done` is 0 and `stim_code` is 2'b01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_len | input | 16 | Samples per correlation window (0 counts as 1) |
| s_valid | input | 1 | Replica sample valid |
| s_ready | output | 1 | Sample ready; high whenever out of reset |
| s_data | input | 8 | Signed replica output code |
| stim_code | output | 2 | Four-level stimulus code {A, B} for the calibration DAC |
| corr_a | output | 20 | Correlation against stream A, signed |
| corr_b | output | 20 | Correlation against stream B, signed |
| corr_ab | output | 20 | Correlation against the product sequence, signed |
| fc_code | output | 8 | Centre-frequency bias code, shared with the main paths |
| done | output | 1 | One-cycle pulse marking new results |

## Verification
Two conditions are hard to reach from the ports. The first is saturation, which needs a long window of full-scale samples; the bench uses a 5000-sample window of constant extremes to push the frequency sum past both limits. The second is the clamp on the bias code. Large constant biases over short windows drive the code past 0 and past 255. A window length of 0 is also used to produce back-to-back `done` pulses. Idle gaps are placed across a stimulus period boundary to show that invalid cycles neither step the sequences nor touch the accumulators.

// File: rtl/calcorr_pkg.sv
package calcorr_pkg;
  typedef enum logic [1:0] {CS_A = 2'd0, CS_B = 2'd1, CS_AB = 2'd2} corr_sel_e;

  // sign bit for a correlator: 1 means add, 0 means subtract
  function automatic logic pick_sign(corr_sel_e sel, logic a, logic b);
    case (sel)
      CS_A:    return a;
      CS_B:    return b;
      default: return ~(a ^ b);
    endcase
  endfunction
endpackage

// File: rtl/calcorr_lfsr.sv
module calcorr_lfsr #(
  parameter int W = 7,
  parameter int TAP = 6,
  parameter logic [W-1:0] SEED = 7'h01
) (
  input  logic clk,
  input  logic rst_n,
  input  logic step,
  output logic bit_o
);
  logic [W-1:0] s_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    s_q <= SEED;
    else if (step) s_q <= {s_q[W-2:0], s_q[W-1] ^ s_q[TAP-1]};
  end
  assign bit_o = s_q[W-1];
endmodule

// File: rtl/calcorr_acc.sv
module calcorr_acc #(
  parameter int DW = 8,
  parameter int AW = 20
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 add_en,
  input  logic                 dump,
  input  logic signed [DW:0]   term,
  output logic signed [AW-1:0] total,
  output logic signed [AW-1:0] result
);
  localparam logic signed [AW+1:0] SMAX = {3'b000, {(AW-1){1'b1}}};
  localparam logic signed [AW+1:0] SMIN = {3'b111, {(AW-1){1'b0}}};

  logic signed [AW-1:0] acc_q, res_q;
  logic signed [AW+1:0] wide;

  always_comb begin
    wide = {{2{acc_q[AW-1]}}, acc_q} + {{(AW+1-DW){term[DW]}}, term};
    if (wide > SMAX)      total = SMAX[AW-1:0];
    else if (wide < SMIN) total = SMIN[AW-1:0];
    else                  total = wide[AW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      res_q <= '0;
    end else if (add_en) begin
      if (dump) begin
        res_q <= total;
        acc_q <= '0;
      end else begin
        acc_q <= total;
      end
    end
  end
  assign result = res_q;
endmodule

// File: rtl/calcorr_servo.sv
module calcorr_servo #(
  parameter int AW = 20,
  parameter int GAIN_SHIFT = 4,
  parameter logic [7:0] FC_INIT = 8'd128
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 upd,
  input  logic signed [AW-1:0] sum,
  output logic [7:0]           code
);
  localparam logic signed [AW+1:0] CODE_MAX = (AW+2)'(255);
  logic [7:0]           code_q;
  logic signed [AW-1:0] delta;
  logic signed [AW+1:0] nxt;
  logic [7:0]           clamped;

  always_comb begin
    delta = sum >>> GAIN_SHIFT;
    nxt = $signed({{(AW-6){1'b0}}, code_q}) - {{2{delta[AW-1]}}, delta};
    if (nxt < 0)             clamped = 8'd0;
    else if (nxt > CODE_MAX) clamped = 8'd255;
    else                     clamped = nxt[7:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   code_q <= FC_INIT;
    else if (upd) code_q <= clamped;
  end
  assign code = code_q;
endmodule

// File: rtl/cal_corr_engine.sv
module cal_corr_engine #(
  parameter int DW = 8,
  parameter int AW = 20,
  parameter int LEN_W = 16,
  parameter int PERIOD = 64,
  parameter int GAIN_SHIFT = 4,
  parameter logic [6:0] SEED_A = 7'h01,
  parameter logic [6:0] SEED_B = 7'h5A
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [LEN_W-1:0]     cfg_len,
  input  logic                 s_valid,
  output logic                 s_ready,
  input  logic [DW-1:0]        s_data,
  output logic [1:0]           stim_code,
  output logic signed [AW-1:0] corr_a,
  output logic signed [AW-1:0] corr_b,
  output logic signed [AW-1:0] corr_ab,
  output logic [7:0]           fc_code,
  output logic                 done
);
  import calcorr_pkg::*;
  localparam int PH_W = $clog2(PERIOD);
  localparam int NSEQ = 2;
  localparam int NCORR = 3;

  logic             ready_q, done_q;
  logic [PH_W-1:0]  ph_q;
  logic [LEN_W-1:0] cnt_q, len_m1;
  logic             take, step, dump;
  logic [NSEQ-1:0]  seq;
  logic signed [DW:0] ext;
  logic signed [AW-1:0] res [NCORR];
  logic signed [AW-1:0] fsum, fres;

  assign take   = s_valid & ready_q;
  assign step   = take && (ph_q == PH_W'(PERIOD-1));
  assign len_m1 = (cfg_len == '0) ? '0 : cfg_len - 1'b1;
  assign dump   = take && (cnt_q >= len_m1);
  assign ext    = {s_data[DW-1], s_data};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ready_q <= 1'b0;
      done_q  <= 1'b0;
      ph_q    <= '0;
      cnt_q   <= '0;
    end else begin
      ready_q <= 1'b1;
      done_q  <= dump;
      if (take) begin
        ph_q  <= ph_q + 1'b1;
        cnt_q <= dump ? '0 : cnt_q + 1'b1;
      end
    end
  end

  // one LFSR per stimulus stream, each with its own seed
  for (genvar g = 0; g < NSEQ; g++) begin : g_seq
    localparam logic [6:0] SD = (g == 0) ? SEED_A : SEED_B;
    calcorr_lfsr #(.W(7), .TAP(6), .SEED(SD)) u_lfsr (
      .clk(clk), .rst_n(rst_n), .step(step), .bit_o(seq[g]));
  end
  assign stim_code = {seq[0], seq[1]};

  // sign correlators against A, B and their product
  for (genvar k = 0; k < NCORR; k++) begin : g_corr
    logic pos;
    logic signed [DW:0] term;
    logic signed [AW-1:0] tot_unused;
    assign pos  = pick_sign(corr_sel_e'(k), seq[0], seq[1]);
    assign term = pos ? ext : -ext;
    calcorr_acc #(.DW(DW), .AW(AW)) u_acc (
      .clk(clk), .rst_n(rst_n), .add_en(take), .dump(dump),
      .term(term), .total(tot_unused), .result(res[k]));
  end
  assign corr_a  = res[0];
  assign corr_b  = res[1];
  assign corr_ab = res[2];

  // centre-frequency servo path
  calcorr_acc #(.DW(DW), .AW(AW)) u_fsum (
    .clk(clk), .rst_n(rst_n), .add_en(take), .dump(dump),
    .term(ext), .total(fsum), .result(fres));

  calcorr_servo #(.AW(AW), .GAIN_SHIFT(GAIN_SHIFT), .FC_INIT(8'd128)) u_servo (
    .clk(clk), .rst_n(rst_n), .upd(dump), .sum(fsum), .code(fc_code));

  assign s_ready = ready_q;
  assign done    = done_q;
endmodule

// File: rtl/calcorr_chk.sv
module calcorr_chk #(
  parameter int AW = 20
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 s_valid,
  input logic                 s_ready,
  input logic [1:0]           stim_code,
  input logic signed [AW-1:0] corr_a,
  input logic signed [AW-1:0] corr_b,
  input logic signed [AW-1:0] corr_ab,
  input logic [7:0]           fc_code,
  input logic                 done
);
  assert_hold_corr_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(corr_a) && $stable(corr_b) && $stable(corr_ab)));

  assert_hold_fc_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(fc_code));

  assert_stim_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(s_valid && s_ready) |=> $stable(stim_code));

  assert_done_after_take_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(s_valid && s_ready));
endmodule

bind cal_corr_engine calcorr_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
  .stim_code(stim_code), .corr_a(corr_a), .corr_b(corr_b), .corr_ab(corr_ab),
  .fc_code(fc_code), .done(done));

// File: tb/sim_cal_corr_engine.sv
module sim_cal_corr_engine;
  localparam longint SMAX = (64'sd1 <<< 19) - 1;
  localparam longint SMIN = -(64'sd1 <<< 19);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] cfg_len = 16'd64;
  logic s_valid = 1'b0;
  logic s_ready;
  logic [7:0] s_data = 8'd0;
  logic [1:0] stim_code;
  logic signed [19:0] corr_a, corr_b, corr_ab;
  logic [7:0] fc_code;
  logic done;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  cal_corr_engine u0 (
    .clk(clk), .rst_n(rst_n), .cfg_len(cfg_len), .s_valid(s_valid),
    .s_ready(s_ready), .s_data(s_data), .stim_code(stim_code),
    .corr_a(corr_a), .corr_b(corr_b), .corr_ab(corr_ab),
    .fc_code(fc_code), .done(done));

  // reference model state
  logic [6:0] la, lb;
  longint m_acc [4];
  longint m_res [3];
  int m_fc, m_ph, m_cnt;
  bit m_done;

  function automatic longint sat(longint v);
    if (v > SMAX) return SMAX;
    if (v < SMIN) return SMIN;
    return v;
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic model_reset();
    la = 7'h01; lb = 7'h5A;
    foreach (m_acc[i]) m_acc[i] = 0;
    foreach (m_res[i]) m_res[i] = 0;
    m_fc = 128; m_ph = 0; m_cnt = 0; m_done = 0;
  endtask

  task automatic compare_all(input string req);
    chk(stim_code == {la[6], lb[6]}, {req, " R2 stim"}, stim_code, {la[6], lb[6]});
    chk(corr_a == m_res[0], {req, " R4 corr_a"}, corr_a, m_res[0]);
    chk(corr_b == m_res[1], {req, " R4 corr_b"}, corr_b, m_res[1]);
    chk(corr_ab == m_res[2], {req, " R4 corr_ab"}, corr_ab, m_res[2]);
    chk(fc_code == m_fc, {req, " R7 fc_code"}, fc_code, m_fc);
    chk(done == m_done, {req, " R9 done"}, done, m_done);
  endtask

  // call at a negedge; drives one sample, checks at the following negedge
  task automatic send(input logic signed [7:0] d, input string req);
    bit a, b, ab;
    longint dl, s;
    int len;
    s_valid = 1'b1; s_data = d;
    @(negedge clk);
    s_valid = 1'b0;
    a = la[6]; b = lb[6]; ab = ~(a ^ b);
    dl = longint'(d);
    m_acc[0] = sat(m_acc[0] + (a ? dl : -dl));
    m_acc[1] = sat(m_acc[1] + (b ? dl : -dl));
    m_acc[2] = sat(m_acc[2] + (ab ? dl : -dl));
    m_acc[3] = sat(m_acc[3] + dl);
    len = (cfg_len == 0) ? 1 : int'(cfg_len);
    m_cnt++;
    m_done = 0;
    if (m_cnt >= len) begin
      m_cnt = 0;
      m_done = 1;
      for (int i = 0; i < 3; i++) begin m_res[i] = m_acc[i]; m_acc[i] = 0; end
      s = m_acc[3] >>> 4;
      m_fc = m_fc - int'(s);
      if (m_fc < 0) m_fc = 0;
      if (m_fc > 255) m_fc = 255;
      m_acc[3] = 0;
    end
    if (m_ph == 63) begin
      la = {la[5:0], la[6] ^ la[5]};
      lb = {lb[5:0], lb[6] ^ lb[5]};
      m_ph = 0;
    end else m_ph++;
    compare_all(req);
  endtask

  task automatic idle(input int n, input string req);
    for (int i = 0; i < n; i++) begin
      s_valid = 1'b0; s_data = 8'h7F;
      @(negedge clk);
      m_done = 0;
      compare_all(req);
    end
  endtask

  task automatic t_reset();
    chk(corr_a == 0 && corr_b == 0 && corr_ab == 0, "R10 corr reset", corr_a, 0);
    chk(fc_code == 8'd128, "R10 fc reset R8", fc_code, 128);
    chk(done == 1'b0, "R10 done reset", done, 0);
    chk(stim_code == 2'b01, "R10 stim reset R2", stim_code, 1);
    rst_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk(s_ready == 1'b1, "R1 ready after reset", s_ready, 1);
  endtask

  task automatic t_zero();
    cfg_len = 16'd64;
    for (int i = 0; i < 128; i++) send(8'sd0, "zero");
    chk(fc_code == 8'd128, "R7 zero mean keeps fc", fc_code, 128);
  endtask

  task automatic t_pattern();
    cfg_len = 16'd100;
    for (int i = 0; i < 300; i++) send(8'((i * 37 + 11) % 256), "pattern R4 R3");
    chk(corr_a != 0 || corr_b != 0, "R4 nonzero correlation", corr_a, 1);
  endtask

  task automatic t_idle_gap();
    // gaps across a stimulus period boundary
    cfg_len = 16'd10;
    for (int i = 0; i < 70; i++) begin
      send(8'sd5, "gap R1 R3");
      if (i % 7 == 3) idle(3, "gap idle R1");
    end
    while (m_cnt != 0) send(8'sd1, "gap flush R5");
  endtask

  task automatic t_clamp();
    cfg_len = 16'd16;
    for (int i = 0; i < 48; i++) send(8'sd100, "clamp low R8");
    chk(fc_code == 8'd0, "R8 clamp at 0", fc_code, 0);
    for (int i = 0; i < 48; i++) send(-8'sd128, "clamp high R8");
    chk(fc_code == 8'd255, "R8 clamp at 255", fc_code, 255);
  endtask

  task automatic t_len_zero();
    cfg_len = 16'd0;
    send(8'sd3, "len0 R5");
    chk(done == 1'b1, "R5 len0 dump first", done, 1);
    send(-8'sd7, "len0 R5");
    chk(done == 1'b1, "R5 len0 back to back R9", done, 1);
    send(8'sd2, "len0 R5");
    idle(1, "len0 idle R9");
    chk(done == 1'b0, "R9 done drops", done, 0);
  endtask

  task automatic t_sat();
    cfg_len = 16'd5000;
    for (int i = 0; i < 5000; i++) send(8'sd127, "sat hi R6");
    chk(fc_code == 8'd0, "R6 positive saturation drives fc low", fc_code, 0);
    for (int i = 0; i < 5000; i++) send(-8'sd128, "sat lo R6");
    chk(fc_code == 8'd255, "R6 negative saturation drives fc high", fc_code, 255);
  endtask

  initial begin
    #(200000 * 8);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    t_reset();
    t_zero();
    t_pattern();
    t_idle_gap();
    t_clamp();
    t_len_zero();
    t_sat();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule